// File: doc/BRIEF.md
# Three-Wire Synthesizer Divider Loader

This block receives a three-wire serial stream (a bit clock, a data line and a load strobe) and holds the divide settings that a frequency synthesizer's counters read. Bits enter a shift register one per rising bit-clock edge, most significant bit first. When the load strobe rises, the last bit received picks the destination. Either the reference group takes the word (a 14-bit reference count plus one auxiliary setting bit) or the main group does (an 11-bit main count plus a 7-bit swallow count).

The three serial inputs are treated as asynchronous. They pass through synchronizer chains into the system clock domain, and every action is taken on a detected edge. The load-strobe level also drives the enable of the loop-filter bypass switch. An open load-strobe pin reads high, so the strobe's synchronizer resets to high. This means the bypass is enabled out of reset, and the first real load needs a low-to-high transition.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, the reference count, auxiliary bit, swallow count and main count outputs are all zero, and the bypass enable is 1 while the load strobe is held high.
- R2: Each rising edge of the bit clock shifts the current data bit into bit 0 of the shift register. Earlier bits move toward the most significant end, so a word is sent most significant bit first.
- R3: A load whose final bit is 1 updates the reference group. The 16 bits sent are, in order: the auxiliary bit, the 14-bit reference count MSB first, then the 1. The main group stays unchanged.
- R4: A load whose final bit is 0 updates the main group. The 19 bits sent are, in order: the 11-bit main count MSB first, the 7-bit swallow count MSB first, then the 0. The reference group stays unchanged.
- R5: Only the most recent bits of the selected word length count. Any bits shifted in before them are discarded.
- R6: While bits are being shifted and the load strobe has not risen, none of the latched outputs change.
- R7: The bypass enable output is 1 while the load strobe is high and 0 while it is low, after the synchronizer delay.
- R8: A transfer happens only on a rising load strobe. Bits clocked in while the strobe is already high are not transferred until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Load strobe (asynchronous, idles high) |
| ref_cnt_o | output | 14 | Latched reference count |
| ref_aux_o | output | 1 | Latched auxiliary setting bit |
| swal_cnt_o | output | 7 | Latched swallow count |
| main_cnt_o | output | 11 | Latched main count |
| bypass_en_o | output | 1 | Bypass switch enable |

## Verification
A fault in the shift register shows up as a word that is rotated or bit-flipped. It appears on the latched outputs about four system cycles after the next load strobe rises. A wrong destination decision changes the group that should have stayed untouched. A faulty edge detector either makes an output move while bits are being shifted or makes a load be lost. Both are visible by the end of that same word. Sweeps over walking-one reference counts and all swallow values expose any field that is misplaced or truncated.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;
  // Destination chosen by the final bit of a serial word.
  typedef enum logic {
    DEST_MAIN = 1'b0,
    DEST_REF  = 1'b1
  } dest_e;

  // Shift register length: longest word plus the steering bit.
  function automatic int sr_len(input int ref_cnt_w, input int swal_w, input int main_w);
    int ref_word;
    int main_word;
    ref_word  = ref_cnt_w + 1;
    main_word = swal_w + main_w;
    return ((ref_word > main_word) ? ref_word : main_word) + 1;
  endfunction
endpackage

// File: rtl/synth_prog_sync.sv
`timescale 1ns/1ps
module synth_prog_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/synth_prog_edge.sv
`timescale 1ns/1ps
module synth_prog_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_VAL;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/synth_prog_shifter.sv
`timescale 1ns/1ps
module synth_prog_shifter #(
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[SR_W-2:0], bit_i};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/synth_prog_latch_bank.sv
`timescale 1ns/1ps
module synth_prog_latch_bank
  import synth_prog_pkg::*;
#(
  parameter int REF_CNT_W = 14,
  parameter int SWAL_W    = 7,
  parameter int MAIN_W    = 11,
  parameter int SR_W      = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  dest_e                dest_i,
  input  logic [SR_W-1:0]      sr_i,
  output logic [REF_CNT_W-1:0] ref_cnt_o,
  output logic                 ref_aux_o,
  output logic [SWAL_W-1:0]    swal_o,
  output logic [MAIN_W-1:0]    main_o
);
  localparam int AUX_POS  = REF_CNT_W + 1;
  localparam int MAIN_LSB = SWAL_W + 1;
  localparam int MAIN_MSB = SWAL_W + MAIN_W;

  function automatic logic [REF_CNT_W-1:0] take_ref(input logic [SR_W-1:0] s);
    return s[REF_CNT_W:1];
  endfunction

  function automatic logic [SWAL_W-1:0] take_swal(input logic [SR_W-1:0] s);
    return s[SWAL_W:1];
  endfunction

  function automatic logic [MAIN_W-1:0] take_main(input logic [SR_W-1:0] s);
    return s[MAIN_MSB:MAIN_LSB];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_o <= '0;
      ref_aux_o <= 1'b0;
    end else if (load_i && dest_i == DEST_REF) begin
      ref_cnt_o <= take_ref(sr_i);
      ref_aux_o <= sr_i[AUX_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swal_o <= '0;
      main_o <= '0;
    end else if (load_i && dest_i == DEST_MAIN) begin
      swal_o <= take_swal(sr_i);
      main_o <= take_main(sr_i);
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
`timescale 1ns/1ps
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int REF_CNT_W   = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk_i,
  input  logic                 ser_dat_i,
  input  logic                 ser_le_i,
  output logic [REF_CNT_W-1:0] ref_cnt_o,
  output logic                 ref_aux_o,
  output logic [SWAL_W-1:0]    swal_cnt_o,
  output logic [MAIN_W-1:0]    main_cnt_o,
  output logic                 bypass_en_o
);
  localparam int SR_W = sr_len(REF_CNT_W, SWAL_W, MAIN_W);

  logic            sclk_s, dat_s, le_s;
  logic            sclk_rise, le_rise;
  logic [SR_W-1:0] sr;
  dest_e           ctrl_bit;

  synth_prog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .q_o(sclk_s));
  synth_prog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d_i(ser_dat_i), .q_o(dat_s));
  synth_prog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_le (
    .clk(clk), .rst_n(rst_n), .d_i(ser_le_i), .q_o(le_s));

  synth_prog_edge #(.RST_VAL(1'b0)) u_edge_clk (
    .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s), .rise_o(sclk_rise));
  synth_prog_edge #(.RST_VAL(1'b1)) u_edge_le (
    .clk(clk), .rst_n(rst_n), .lvl_i(le_s), .rise_o(le_rise));

  synth_prog_shifter #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(sclk_rise), .bit_i(dat_s), .sr_o(sr));

  assign ctrl_bit = dest_e'(sr[0]);

  synth_prog_latch_bank #(
    .REF_CNT_W(REF_CNT_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .SR_W(SR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .load_i(le_rise), .dest_i(ctrl_bit), .sr_i(sr),
    .ref_cnt_o(ref_cnt_o), .ref_aux_o(ref_aux_o),
    .swal_o(swal_cnt_o), .main_o(main_cnt_o));

  assign bypass_en_o = le_s;
endmodule

// File: rtl/synth_prog_chk.sv
`timescale 1ns/1ps
module synth_prog_chk #(
  parameter int REF_CNT_W = 14,
  parameter int SWAL_W    = 7,
  parameter int MAIN_W    = 11,
  parameter int SR_W      = 19
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sclk_rise,
  input logic                 le_rise,
  input logic                 dat_s,
  input logic [SR_W-1:0]      sr,
  input logic [REF_CNT_W-1:0] ref_cnt_o,
  input logic                 ref_aux_o,
  input logic [SWAL_W-1:0]    swal_cnt_o,
  input logic [MAIN_W-1:0]    main_cnt_o
);
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sr[0] == $past(dat_s));

  a_r3_ref_value: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sr[0]) |=> ref_cnt_o == $past(sr[REF_CNT_W:1]));

  a_r3_main_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sr[0]) |=> ($stable(swal_cnt_o) && $stable(main_cnt_o)));

  a_r4_main_value: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !sr[0]) |=> swal_cnt_o == $past(sr[SWAL_W:1]));

  a_r4_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !sr[0]) |=> ($stable(ref_cnt_o) && $stable(ref_aux_o)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> ($stable(ref_cnt_o) && $stable(ref_aux_o)
                  && $stable(swal_cnt_o) && $stable(main_cnt_o)));
endmodule

bind synth_prog_if synth_prog_chk #(
  .REF_CNT_W(REF_CNT_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .le_rise(le_rise),
  .dat_s(dat_s), .sr(sr), .ref_cnt_o(ref_cnt_o), .ref_aux_o(ref_aux_o),
  .swal_cnt_o(swal_cnt_o), .main_cnt_o(main_cnt_o));

// File: tb/synth_prog_if_bench.sv
`timescale 1ns/1ps
module synth_prog_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b1;
  logic [13:0] ref_cnt;
  logic        ref_aux;
  logic [6:0]  swal;
  logic [10:0] main_cnt;
  logic        bypass;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_prog_if u_synth_prog_if (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_le_i(ser_le), .ref_cnt_o(ref_cnt), .ref_aux_o(ref_aux),
    .swal_cnt_o(swal), .main_cnt_o(main_cnt), .bypass_en_o(bypass));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;  wait_cyc(4);
    ser_clk = 1'b1; wait_cyc(4);
    ser_clk = 1'b0; wait_cyc(4);
  endtask

  task automatic shift_word(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; wait_cyc(8);
    chk("R7 bypass high", {31'd0, bypass}, 32'd1);
    ser_le = 1'b0; wait_cyc(8);
    chk("R7 bypass low", {31'd0, bypass}, 32'd0);
  endtask

  function automatic logic [31:0] ref_word(input logic aux, input logic [13:0] c);
    return {16'd0, aux, c, 1'b1};
  endfunction

  function automatic logic [31:0] main_word(input logic [10:0] n, input logic [6:0] a);
    return {13'd0, n, a, 1'b0};
  endfunction

  logic [14:0] exp_ref;   // {aux, count}
  logic [17:0] exp_main;  // {main, swallow}

  task automatic check_all(input string req);
    chk(req, {17'd0, ref_aux, ref_cnt}, {17'd0, exp_ref});
    chk(req, {14'd0, main_cnt, swal}, {14'd0, exp_main});
  endtask

  initial begin
    wait_cyc(5);
    exp_ref = '0; exp_main = '0;
    check_all("R1 reset outputs");
    rst_n = 1'b1; wait_cyc(8);
    check_all("R1 after release");
    chk("R1 bypass with strobe high", {31'd0, bypass}, 32'd1);
    ser_le = 1'b0; wait_cyc(8);
    chk("R7 strobe low", {31'd0, bypass}, 32'd0);
    check_all("R1 no load on falling strobe");

    // R3 / R2: reference sweep with walking ones and patterns
    for (int k = 0; k < 16; k++) begin
      logic [13:0] c;
      logic aux;
      c = (k < 14) ? 14'(1 << k) : ((k == 14) ? 14'h3FFF : 14'h2A5C);
      aux = k[0];
      shift_word(ref_word(aux, c), 16);
      check_all("R6 no change while shifting");
      pulse_le();
      exp_ref = {aux, c};
      check_all("R3 R2 reference load");
    end

    // R4: every swallow value with computed main counts
    for (int a = 0; a < 128; a++) begin
      logic [10:0] n;
      n = 11'((a * 37 + 5) % 2048);
      if (a == 127) n = 11'h7FF;
      shift_word(main_word(n, 7'(a)), 19);
      check_all("R6 no change while shifting");
      pulse_le();
      exp_main = {n, 7'(a)};
      check_all("R4 main load");
    end

    // R5: leading junk discarded
    shift_word(32'h7F, 7);
    shift_word(ref_word(1'b0, 14'h1234), 16);
    pulse_le();
    exp_ref = {1'b0, 14'h1234};
    check_all("R5 junk before reference word");
    shift_word(32'hA, 4);
    shift_word(main_word(11'h456, 7'h2B), 19);
    pulse_le();
    exp_main = {11'h456, 7'h2B};
    check_all("R5 junk before main word");

    // R8: clocking with the strobe already high transfers nothing
    ser_le = 1'b1; wait_cyc(8);
    shift_word(ref_word(1'b1, 14'h0ACE), 16);
    wait_cyc(8);
    check_all("R8 no transfer while strobe held high");
    ser_le = 1'b0; wait_cyc(8);
    check_all("R8 no transfer on fall");
    pulse_le();
    exp_ref = {1'b1, 14'h0ACE};
    check_all("R8 transfer on next rise");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule